// File: doc/BRIEF.md
# Shared Candidate Memory Scheduler for a Four-Core Hash Unit

This block sits between one password-candidate generator, four hash cores and a single two-ported candidate memory. It also holds the target salt and target hash that all four cores compare against. A host first loads the 128-bit salt and the 192-bit hash, then raises a start flag. The block accepts that flag only once both targets have been loaded. After the start is accepted, the targets are frozen for the rest of the run.

The memory is split into two banks of four candidate slots. The generator always fills the bank that the cores are not reading. The cores take one candidate each from the other bank: core i reads slot i. When every core has taken its candidate and the fill bank is complete, the two banks change roles. While the cores run their long initialisation, the generator can refill the idle bank.

Each cycle the memory offers two ports. An accepted generator write takes one of them. Read grants go to eligible cores, lowest index first. Cores 0 and 1 are released together as soon as the start is accepted. Cores 2 and 3 are released a fixed 19 cycles later, so the two pairs never compete for the memory at the same moment. When a core signals a hit, the block latches the reporting core's index and the candidate that core last received, so the host can read them.

Top module: `pwsched_quad`

## Requirements
- R1: After reset no core is released or granted, no match is reported, and the generator sees gen_ready high.
- R2: A salt or hash write updates salt_o or hash_o only before the start has been accepted. Once the run begins, both registers hold their values and further writes are ignored.
- R3: A start pulse is accepted only if both the salt and the hash were written in earlier cycles. A start pulse without both targets is dropped and does not take effect later.
- R4: Cores 0 and 1 are released (core_go high) in the cycle after the accepted start. Cores 2 and 3 are released exactly 19 cycles later. No core is granted before it is released.
- R5: Generator writes fill slots 0 to 3 of the fill bank in order. gen_ready is low while the fill bank holds four candidates, and a write made while gen_ready is low is ignored.
- R6: The banks change roles when the fill bank is full and either every core has taken its slot from the read bank or the read bank is empty. Core i always receives slot i of the read bank.
- R7: A grant is combinational in the request cycle. It goes only to a requesting, released core that has not yet taken its slot from the current read bank. At most two grants are given per cycle, and at most one in a cycle with an accepted generator write. Eligible cores are served lowest index first.
- R8: The granted candidate appears on the core's data lane in the cycle after the grant and stays there until that core's next grant.
- R9: The first hit from a released core sets found and latches the core's index and its current candidate. Among simultaneous hits the lowest index wins. These values hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| salt_we | input | 1 | Salt write strobe |
| salt_in | input | 128 | Salt value |
| hash_we | input | 1 | Target hash write strobe |
| hash_in | input | 192 | Target hash value |
| start | input | 1 | Start request |
| gen_we | input | 1 | Generator write strobe |
| gen_data | input | 64 | Candidate written by the generator |
| gen_ready | output | 1 | Fill bank has a free slot |
| core_req | input | 4 | Per-core read request |
| core_go | output | 4 | Per-core release |
| core_gnt | output | 4 | Per-core read grant |
| core_rd_data | output | 256 | Per-core candidate lane, core i at bits 64*i+63:64*i |
| core_hit | input | 4 | Per-core match indication |
| salt_o | output | 128 | Shared salt |
| hash_o | output | 192 | Shared target hash |
| found | output | 1 | A match has been recorded |
| found_core | output | 2 | Index of the matching core |
| found_pw | output | 64 | Candidate that matched |

## Verification
The first request pattern has all four cores asking at once with no generator write. It should show the two-grant limit and the 19-cycle gap between the pairs, measured from the first pair's grant cycle. The second pattern has all four cores asking in the same cycle as a generator write, then trailing requests. This separates the one-grant and two-grant cases and shows the lowest-first ordering. Simultaneous hits, late hits, writes to a full bank, target writes after the run starts and a premature start each check that the dropped input leaves the observable state unchanged.

// File: rtl/pwsched_pkg.sv
package pwsched_pkg;
    localparam int MEM_PORTS = 2;
    localparam int BANKS     = 2;

    function automatic int pair_of(input int core_idx);
        return core_idx / 2;
    endfunction
endpackage

// File: rtl/pwsched_targets.sv
module pwsched_targets #(
    parameter int SALT_W = 128,
    parameter int HASH_W = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              salt_we,
    input  logic [SALT_W-1:0] salt_in,
    input  logic              hash_we,
    input  logic [HASH_W-1:0] hash_in,
    input  logic              start,
    output logic [SALT_W-1:0] salt_o,
    output logic [HASH_W-1:0] hash_o,
    output logic              run
);
    typedef struct packed {
        logic [SALT_W-1:0] salt;
        logic [HASH_W-1:0] hash;
        logic              salt_ok;
        logic              hash_ok;
        logic              run;
    } tgt_t;

    tgt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (salt_we) begin
                st_d.salt    = salt_in;
                st_d.salt_ok = 1'b1;
            end
            if (hash_we) begin
                st_d.hash    = hash_in;
                st_d.hash_ok = 1'b1;
            end
            if (start && st_q.salt_ok && st_q.hash_ok)
                st_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign salt_o = st_q.salt;
    assign hash_o = st_q.hash;
    assign run    = st_q.run;
endmodule

// File: rtl/pwsched_stagger.sv
module pwsched_stagger
    import pwsched_pkg::*;
#(
    parameter int N_CORE     = 4,
    parameter int PAIR_DELAY = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [N_CORE-1:0] go
);
    localparam int LAST  = (N_CORE / 2 - 1) * PAIR_DELAY;
    localparam int CNT_W = $clog2(LAST + 2);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)                     cnt_d = '0;
        else if (int'(cnt_q) < LAST)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar i = 0; i < N_CORE; i++) begin : g_go
        localparam int THR = pair_of(i) * PAIR_DELAY;
        assign go[i] = run && (int'(cnt_q) >= THR);
    end
endmodule

// File: rtl/pwsched_arb.sv
module pwsched_arb
    import pwsched_pkg::*;
#(
    parameter int N_CORE = 4
) (
    input  logic [N_CORE-1:0] elig,
    input  logic              port_taken,
    output logic [N_CORE-1:0] gnt
);
    always_comb begin
        int used;
        int limit;
        used  = 0;
        limit = port_taken ? MEM_PORTS - 1 : MEM_PORTS;
        gnt   = '0;
        for (int i = 0; i < N_CORE; i++) begin
            if (elig[i] && used < limit) begin
                gnt[i] = 1'b1;
                used   = used + 1;
            end
        end
    end
endmodule

// File: rtl/pwsched_quad.sv
module pwsched_quad
    import pwsched_pkg::*;
#(
    parameter int N_CORE     = 4,
    parameter int PW_W       = 64,
    parameter int SALT_W     = 128,
    parameter int HASH_W     = 192,
    parameter int PAIR_DELAY = 19
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   salt_we,
    input  logic [SALT_W-1:0]      salt_in,
    input  logic                   hash_we,
    input  logic [HASH_W-1:0]      hash_in,
    input  logic                   start,
    input  logic                   gen_we,
    input  logic [PW_W-1:0]        gen_data,
    output logic                   gen_ready,
    input  logic [N_CORE-1:0]      core_req,
    output logic [N_CORE-1:0]      core_go,
    output logic [N_CORE-1:0]      core_gnt,
    output logic [N_CORE*PW_W-1:0] core_rd_data,
    input  logic [N_CORE-1:0]      core_hit,
    output logic [SALT_W-1:0]      salt_o,
    output logic [HASH_W-1:0]      hash_o,
    output logic                   found,
    output logic [$clog2(N_CORE)-1:0] found_core,
    output logic [PW_W-1:0]        found_pw
);
    localparam int IDX_W = $clog2(N_CORE);

    typedef struct packed {
        logic              rd_bank;
        logic [BANKS-1:0]  full;
        logic [N_CORE-1:0] cons;
        logic [IDX_W-1:0]  fill_cnt;
        logic              found;
        logic [IDX_W-1:0]  found_core;
        logic [PW_W-1:0]   found_pw;
    } sched_t;

    sched_t          st_d, st_q;
    logic [PW_W-1:0] mem_d [BANKS][N_CORE];
    logic [PW_W-1:0] mem_q [BANKS][N_CORE];
    logic [PW_W-1:0] lane_d [N_CORE];
    logic [PW_W-1:0] lane_q [N_CORE];

    logic              run;
    logic              fill_bank;
    logic              wr_go;
    logic [N_CORE-1:0] elig;

    pwsched_targets #(.SALT_W(SALT_W), .HASH_W(HASH_W)) u_targets (
        .clk(clk), .rst_n(rst_n),
        .salt_we(salt_we), .salt_in(salt_in),
        .hash_we(hash_we), .hash_in(hash_in),
        .start(start),
        .salt_o(salt_o), .hash_o(hash_o), .run(run)
    );

    pwsched_stagger #(.N_CORE(N_CORE), .PAIR_DELAY(PAIR_DELAY)) u_stagger (
        .clk(clk), .rst_n(rst_n), .run(run), .go(core_go)
    );

    assign fill_bank = ~st_q.rd_bank;
    assign gen_ready = ~st_q.full[fill_bank];
    assign wr_go     = gen_we & gen_ready;
    assign elig      = core_req & core_go & ~st_q.cons & {N_CORE{st_q.full[st_q.rd_bank]}};

    pwsched_arb #(.N_CORE(N_CORE)) u_arb (
        .elig(elig), .port_taken(wr_go), .gnt(core_gnt)
    );

    always_comb begin
        logic [N_CORE-1:0] cons_nx;
        st_d   = st_q;
        mem_d  = mem_q;
        lane_d = lane_q;

        if (wr_go) begin
            mem_d[fill_bank][st_q.fill_cnt] = gen_data;
            st_d.fill_cnt = st_q.fill_cnt + 1'b1;
            if (int'(st_q.fill_cnt) == N_CORE - 1)
                st_d.full[fill_bank] = 1'b1;
        end

        for (int i = 0; i < N_CORE; i++)
            if (core_gnt[i]) lane_d[i] = mem_q[st_q.rd_bank][i];

        cons_nx = st_q.cons | core_gnt;
        if (((&cons_nx) || !st_q.full[st_q.rd_bank]) && st_q.full[fill_bank]) begin
            st_d.rd_bank               = fill_bank;
            st_d.full[st_q.rd_bank]    = 1'b0;
            st_d.cons                  = '0;
        end else begin
            st_d.cons = cons_nx;
        end

        if (!st_q.found) begin
            for (int i = N_CORE - 1; i >= 0; i--) begin
                if (core_hit[i] && core_go[i]) begin
                    st_d.found      = 1'b1;
                    st_d.found_core = IDX_W'(i);
                    st_d.found_pw   = lane_q[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int b = 0; b < BANKS; b++)
                for (int i = 0; i < N_CORE; i++)
                    mem_q[b][i] <= '0;
            for (int i = 0; i < N_CORE; i++)
                lane_q[i] <= '0;
        end else begin
            st_q   <= st_d;
            mem_q  <= mem_d;
            lane_q <= lane_d;
        end
    end

    for (genvar i = 0; i < N_CORE; i++) begin : g_lane
        assign core_rd_data[i*PW_W +: PW_W] = lane_q[i];
    end

    assign found      = st_q.found;
    assign found_core = st_q.found_core;
    assign found_pw   = st_q.found_pw;
endmodule

// File: rtl/pwsched_quad_chk.sv
module pwsched_quad_chk #(
    parameter int N_CORE = 4,
    parameter int PW_W   = 64,
    parameter int SALT_W = 128
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_CORE-1:0]         core_req,
    input logic [N_CORE-1:0]         core_go,
    input logic [N_CORE-1:0]         core_gnt,
    input logic                      gen_we,
    input logic                      gen_ready,
    input logic [SALT_W-1:0]         salt_o,
    input logic                      found,
    input logic [$clog2(N_CORE)-1:0] found_core,
    input logic [PW_W-1:0]           found_pw
);
    // R7: grant only to a requester
    a_r7_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (core_gnt & ~core_req) == '0);
    // R7: two memory ports at most
    a_r7_two_ports: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(core_gnt) <= 2);
    // R7: a generator write leaves one port for reads
    a_r7_write_shares: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_we && gen_ready) |-> $countones(core_gnt) <= 1);
    // R4: no grant to a core that is not yet released
    a_r4_no_gnt_before_go: assert property (@(posedge clk) disable iff (!rst_n)
        (core_gnt & ~core_go) == '0);
    // R4: the second pair never runs ahead of the first
    if (N_CORE > 2) begin : g_pair
        a_r4_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
            core_go[2] |-> core_go[0]);
    end
    // R2: salt frozen once running
    a_r2_salt_held: assert property (@(posedge clk) disable iff (!rst_n)
        core_go[0] |=> $stable(salt_o));
    // R9: match record is sticky
    a_r9_found_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> (found && $stable(found_pw) && $stable(found_core)));
endmodule

bind pwsched_quad pwsched_quad_chk #(.N_CORE(N_CORE), .PW_W(PW_W), .SALT_W(SALT_W)) u_chk (.*);

// File: tb/tb_pwsched_quad.sv
`timescale 1ns/100ps
module tb_pwsched_quad;
    localparam int N = 4;
    localparam int W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic salt_we = 1'b0, hash_we = 1'b0, start = 1'b0, gen_we = 1'b0;
    logic [127:0] salt_in = '0;
    logic [191:0] hash_in = '0;
    logic [W-1:0] gen_data = '0;
    logic gen_ready;
    logic [N-1:0] core_req = '0, core_go, core_gnt, core_hit = '0;
    logic [N*W-1:0] core_rd_data;
    logic [127:0] salt_o;
    logic [191:0] hash_o;
    logic found;
    logic [1:0] found_core;
    logic [W-1:0] found_pw;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwsched_quad dut (.*);

    function automatic logic [W-1:0] cand(input int k);
        return 64'hA5A5_0000_0000_0000 + 64'(k) * 64'h0001_0203_0405;
    endfunction

    function automatic logic [W-1:0] lane(input int i);
        return core_rd_data[i*W +: W];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic gen_put(input logic [W-1:0] d);
        @(negedge clk);
        while (!gen_ready) @(negedge clk);
        gen_we = 1'b1; gen_data = d;
        @(negedge clk);
        gen_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(core_go == 0, "R1 go", 192'(core_go), 0);
        chk(core_gnt == 0, "R1 gnt", 192'(core_gnt), 0);
        chk(found == 0, "R1 found", 192'(found), 0);
        chk(gen_ready == 1, "R1 gen_ready", 192'(gen_ready), 1);

        // R3 start with no targets is dropped
        start = 1'b1; @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(core_go == 0, "R3 start without targets", 192'(core_go), 0);

        // R2 salt load, R3 start with salt only
        salt_in = 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687; salt_we = 1'b1;
        @(negedge clk); salt_we = 1'b0;
        chk(salt_o == salt_in, "R2 salt load", 192'(salt_o), 192'(salt_in));
        start = 1'b1; @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(core_go == 0, "R3 start with salt only", 192'(core_go), 0);
        hash_in = 192'hDEAD_BEEF_0000_1111_2222_3333_4444_5555_6666_7777_8888_9999; hash_we = 1'b1;
        @(negedge clk); hash_we = 1'b0;
        chk(hash_o == hash_in, "R2 hash load", hash_o, hash_in);
        chk(core_go == 0, "R3 dropped start not remembered", 192'(core_go), 0);

        // R5 fill both banks
        for (int c = 0; c < 8; c++) gen_put(cand(c));
        @(negedge clk);
        chk(gen_ready == 0, "R5 both banks full", 192'(gen_ready), 0);
        gen_we = 1'b1; gen_data = 64'hDEAD_DEAD_DEAD_DEAD;
        @(negedge clk); gen_we = 1'b0;
        chk(gen_ready == 0, "R5 write while full ignored", 192'(gen_ready), 0);

        // R4 start, first pair granted in parallel
        core_req = 4'b1111; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(core_go == 4'b0011, "R4 first pair released", 192'(core_go), 192'(4'b0011));
        chk(core_gnt == 4'b0011, "R7 first pair two grants", 192'(core_gnt), 192'(4'b0011));
        @(negedge clk);
        chk(lane(0) == cand(0), "R8 core0 slot0", 192'(lane(0)), 192'(cand(0)));
        chk(lane(1) == cand(1), "R6 core1 slot1", 192'(lane(1)), 192'(cand(1)));
        core_req = 4'b1100;
        k = 1;
        while (core_gnt[2] == 1'b0 && k < 60) begin
            @(negedge clk); k++;
        end
        chk(k == 19, "R4 second pair delay", 192'(k), 19);
        chk(core_gnt == 4'b1100, "R7 second pair two grants", 192'(core_gnt), 192'(4'b1100));
        chk(core_go == 4'b1111, "R4 all released", 192'(core_go), 192'(4'b1111));
        @(negedge clk); core_req = '0;
        chk(lane(2) == cand(2), "R8 core2 slot2", 192'(lane(2)), 192'(cand(2)));
        chk(lane(3) == cand(3), "R8 core3 slot3", 192'(lane(3)), 192'(cand(3)));
        chk(lane(0) == cand(0), "R8 core0 held", 192'(lane(0)), 192'(cand(0)));
        chk(gen_ready == 1, "R6 swap frees fill bank", 192'(gen_ready), 1);

        // R7 write shares the ports, lowest index first
        core_req = 4'b1111; gen_we = 1'b1; gen_data = cand(8);
        #1 chk(core_gnt == 4'b0001, "R7 one grant with write", 192'(core_gnt), 192'(4'b0001));
        @(negedge clk); gen_we = 1'b0; core_req = 4'b1110;
        #1 chk(core_gnt == 4'b0110, "R7 lowest first", 192'(core_gnt), 192'(4'b0110));
        chk(lane(0) == cand(4), "R6 swapped bank core0", 192'(lane(0)), 192'(cand(4)));
        @(negedge clk); core_req = 4'b1000;
        #1 chk(core_gnt == 4'b1000, "R7 last core", 192'(core_gnt), 192'(4'b1000));
        chk(lane(1) == cand(5), "R5 ignored write left slot1", 192'(lane(1)), 192'(cand(5)));
        chk(lane(2) == cand(6), "R6 core2 slot2", 192'(lane(2)), 192'(cand(6)));
        @(negedge clk); core_req = 4'b0001;
        #1 chk(core_gnt == 4'b0000, "R7 no second take", 192'(core_gnt), 0);
        chk(lane(3) == cand(7), "R8 core3 slot3", 192'(lane(3)), 192'(cand(7)));
        @(negedge clk); core_req = '0;

        // R9 simultaneous hits
        core_hit = 4'b1100;
        @(negedge clk); core_hit = '0;
        chk(found == 1, "R9 found", 192'(found), 1);
        chk(found_core == 2, "R9 lowest hit wins", 192'(found_core), 2);
        chk(found_pw == cand(6), "R9 candidate", 192'(found_pw), 192'(cand(6)));
        core_hit = 4'b0001;
        @(negedge clk); core_hit = '0;
        @(negedge clk);
        chk(found_core == 2, "R9 sticky", 192'(found_core), 2);

        // R2 writes ignored while running
        salt_we = 1'b1; salt_in = '1; hash_we = 1'b1; hash_in = '0;
        @(negedge clk); salt_we = 1'b0; hash_we = 1'b0;
        chk(salt_o == 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687, "R2 salt frozen",
            192'(salt_o), 192'(128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687));
        chk(hash_o == 192'hDEAD_BEEF_0000_1111_2222_3333_4444_5555_6666_7777_8888_9999,
            "R2 hash frozen", hash_o,
            192'hDEAD_BEEF_0000_1111_2222_3333_4444_5555_6666_7777_8888_9999);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule